// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a received byte stream and stores it in system memory through a ring of descriptors that software keeps in that same memory. Each descriptor is two 32-bit words. The first word carries the buffer address, a wrap marker and an ownership flag. The second word is filled in by the block with the byte count and the frame-boundary flags. Each buffer holds 128 bytes, so a long frame is spread over several consecutive descriptors.

Software takes these steps before reception starts:
1. Build the ring in memory, with every entry owned by hardware.
2. Write the ring base into the queue-pointer register while reception is off.
3. Set the enable bit.

When a frame starts, the block reads the current descriptor. If hardware owns it, the block packs the bytes little-endian into 32-bit words at the buffer address. When the buffer is full or the frame ends, the block writes the descriptor back and moves on to the next entry. If the descriptor is still owned by software, the block discards the rest of the frame and raises a sticky flag. It tries the same descriptor again on the next frame.

The register port has two registers, selected by `reg_addr`:
- Control register (`reg_addr`=0): bit 0 enables reception. Bit 1 selects the loop-back configuration. Bit 2 reads the buffer-unavailable flag, and writing 1 to bit 2 clears it.
- Queue pointer (`reg_addr`=1): a write sets the ring base, which is 8-byte aligned. A read returns the address of the descriptor in use.

Top module: `rxq_ring_dma`

## Requirements
- R1: Descriptor entry k sits at byte address base + 8*k. The queue-pointer register reads back base + 8*(current entry).
- R2: A fetched word 0 with bit 0 equal to 0 means the buffer is free. Frame bytes are then written little-endian, byte j of the buffer going to address (word0 & 0xFFFFFFFC) + j.
- R3: A buffer takes at most 128 bytes. The bytes of a longer frame continue in the next descriptor's buffer, and no write leaves the current buffer's 128-byte range.
- R4: When a buffer is closed, word 0 is written back with bit 0 set to 1 and bits 31:1 unchanged. Word 1 is written with the byte count in bits 11:0, bit 14 set for the first buffer of the frame and bit 15 set for the last.
- R5: After an entry whose word 0 bit 1 is set, the next fetch uses the ring base.
- R6: With no wrap marker present, the entry after entry 1023 is entry 0.
- R7: If a fetched descriptor has bit 0 equal to 1, the rest of the frame is dropped and nothing is written for it. Control bit 2 goes to 1 and stays there until a control write with bit 2 set. The same descriptor is fetched for the next frame.
- R8: Writes to the queue pointer take effect only while reception is disabled.
- R9: Control bit 1 changes only through a write made while reception is disabled that also leaves bit 0 at 0.
- R10: After reset the control register reads 0 and the queue pointer reads 0. Clearing the enable bit returns the current entry to the ring base.
- R11: A memory request keeps its address and direction steady until it is acknowledged. `rx_ready` and `mem_req` stay low while reception is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 queue pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lb_mode | output | 1 | Loop-back configuration bit |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_ready | output | 1 | Byte taken on this edge when `rx_valid` is high |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Single-cycle acknowledge |

## Verification
The assertions watch these rules on every cycle:
- the memory request holds its address and direction until acknowledged;
- the enable bit locks the queue pointer and the loop-back bit;
- the buffer-unavailable flag stays set until it is cleared;
- clearing enable resets the entry index and silences the stream and memory ports;
- no data write leaves its 128-byte buffer.

The bench scenarios are needed for the rest:
- the contents written to memory, which covers byte packing, the count and boundary flags, and the preserved address and wrap bits;
- splitting a frame across buffers;
- the wrap marker and the 1024-entry wrap;
- the retry of a refused descriptor.

// File: rtl/rxq_pkg.sv
// Shared types for the receive descriptor ring writer.
// Assumes a single clock domain and a 32-bit byte-addressed memory.
package rxq_pkg;
    typedef enum logic [2:0] {
        ST_OFF,    // reception disabled
        ST_IDLE,   // waiting for a frame start
        ST_FETCH,  // reading descriptor word 0
        ST_FILL,   // taking bytes into the packer
        ST_WDATA,  // writing a packed data word
        ST_WB0,    // writing descriptor word 0
        ST_WB1,    // writing descriptor word 1
        ST_DROP    // discarding the rest of a frame
    } rxq_state_t;
endpackage

// File: rtl/rxq_regs.sv
// Control and queue-pointer registers.
// Assumes a one-bit register select. Writes to the configuration are
// accepted only while reception is off, and the queue pointer reads back
// the descriptor currently in use.
module rxq_regs #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             bna_set,
    output logic             rx_en,
    output logic             loop_en,
    output logic [31:0]      q_base,
    output logic             bna,
    output logic [31:0]      rdata
);
    logic ctrl_wr;
    assign ctrl_wr = wr && !sel;

    // Purpose: enable bit, locked configuration bit and locked ring base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en   <= 1'b0;
            loop_en <= 1'b0;
            q_base  <= '0;
        end else begin
            if (ctrl_wr) begin
                rx_en <= wdata[0];
                if (!rx_en && !wdata[0])
                    loop_en <= wdata[1];
            end
            if (wr && sel && !rx_en)
                q_base <= {wdata[31:3], 3'b000};
        end
    end

    // Purpose: sticky buffer-unavailable flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bna <= 1'b0;
        else if (bna_set)
            bna <= 1'b1;
        else if (ctrl_wr && wdata[2])
            bna <= 1'b0;
    end

    // Purpose: read mux; the queue pointer shows the entry in use.
    always_comb begin
        if (sel)
            rdata = q_base + {{(29-IDX_W){1'b0}}, cur_idx, 3'b000};
        else
            rdata = {29'd0, bna, loop_en, rx_en};
    end
endmodule

// File: rtl/rxq_pack.sv
// Byte packer: collects bytes little-endian into one 32-bit word and
// counts the bytes placed in the current buffer.
// Assumes the caller flushes the word after lane 3 or at frame end.
module rxq_pack #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [7:0]       din,
    output logic [31:0]      word,
    output logic [CNT_W-1:0] cnt
);
    logic [1:0] lane;
    assign lane = cnt[1:0];

    // Purpose: place each byte in its lane and advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            word <= '0;
        end else if (clr) begin
            cnt  <= '0;
            word <= '0;
        end else if (push) begin
            cnt <= cnt + 1'b1;
            if (lane == 2'd0)
                word <= {24'd0, din};
            else
                word[8*lane +: 8] <= din;
        end
    end
endmodule

// File: rtl/rxq_ring_dma.sv
// Receive descriptor ring writer (top).
// Fetches the current descriptor, fills its buffer with frame bytes,
// writes the descriptor back and advances around the ring, wrapping on
// the wrap marker or after RING_MAX entries.
// Assumes memory acknowledges each held request with one mem_ack pulse.
module rxq_ring_dma
    import rxq_pkg::*;
#(
    parameter int BUF_BYTES = 128,
    parameter int RING_MAX  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        lb_mode,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    output logic        rx_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam int IDX_W = $clog2(RING_MAX);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_BYTES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BUF_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_MAX - 1);

    rxq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [31:2]      buf_addr;
    logic             wrap_q, first_q, eof_q;
    logic             rx_en, bna, bna_set;
    logic [31:0]      q_base, desc_addr, buf_base, word;
    logic [CNT_W-1:0] cnt, cnt_m1;
    logic             pack_clr, pack_push, state_wdata;

    rxq_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_addr),
        .wdata(reg_wdata), .cur_idx(idx), .bna_set(bna_set),
        .rx_en(rx_en), .loop_en(lb_mode), .q_base(q_base), .bna(bna),
        .rdata(reg_rdata)
    );

    rxq_pack #(.CNT_W(CNT_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pack_clr), .push(pack_push),
        .din(rx_data), .word(word), .cnt(cnt)
    );

    // Purpose: addresses derived from ring position and buffer pointer.
    assign desc_addr   = q_base + {{(29-IDX_W){1'b0}}, idx, 3'b000};
    assign buf_base    = {buf_addr, 2'b00};
    assign cnt_m1      = cnt - 1'b1;
    assign state_wdata = (state == ST_WDATA);

    // Purpose: stream handshake, packer controls and flag pulse.
    assign rx_ready  = (state == ST_FILL) || (state == ST_DROP);
    assign pack_push = (state == ST_FILL) && rx_valid;
    assign pack_clr  = (state == ST_FETCH) && mem_ack && !mem_rdata[0];
    assign bna_set   = (state == ST_FETCH) && mem_ack && mem_rdata[0];

    // Purpose: memory request, held by the state until acknowledged.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        case (state)
            ST_FETCH: mem_req = 1'b1;
            ST_WDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_base + 32'({cnt_m1[CNT_W-1:2], 2'b00});
                mem_wdata = word;
            end
            ST_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {buf_addr, wrap_q, 1'b1};
            end
            ST_WB1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + 32'd4;
                mem_wdata = {16'd0, eof_q, first_q, 2'b00,
                             {(12-CNT_W){1'b0}}, cnt};
            end
            default: ;
        endcase
    end

    // Purpose: ring walk state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            idx      <= '0;
            buf_addr <= '0;
            wrap_q   <= 1'b0;
            first_q  <= 1'b0;
            eof_q    <= 1'b0;
        end else if (!rx_en) begin
            state <= ST_OFF;
            idx   <= '0;
        end else begin
            case (state)
                ST_OFF: state <= ST_IDLE;
                ST_IDLE:
                    if (rx_valid && rx_sof) begin
                        first_q <= 1'b1;
                        state   <= ST_FETCH;
                    end
                ST_FETCH:
                    if (mem_ack) begin
                        if (mem_rdata[0]) begin
                            state <= ST_DROP;
                        end else begin
                            buf_addr <= mem_rdata[31:2];
                            wrap_q   <= mem_rdata[1];
                            eof_q    <= 1'b0;
                            state    <= ST_FILL;
                        end
                    end
                ST_FILL:
                    if (rx_valid) begin
                        if (rx_eof)
                            eof_q <= 1'b1;
                        if (cnt[1:0] == 2'd3 || rx_eof || cnt == LAST_CNT)
                            state <= ST_WDATA;
                    end
                ST_WDATA:
                    if (mem_ack)
                        state <= (eof_q || cnt == FULL_CNT) ? ST_WB0 : ST_FILL;
                ST_WB0:
                    if (mem_ack)
                        state <= ST_WB1;
                ST_WB1:
                    if (mem_ack) begin
                        idx     <= (wrap_q || idx == LAST_IDX) ? '0 : idx + 1'b1;
                        first_q <= 1'b0;
                        state   <= eof_q ? ST_IDLE : ST_FETCH;
                    end
                ST_DROP:
                    if (rx_valid && rx_eof)
                        state <= ST_IDLE;
                default: state <= ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/rxq_ring_chk.sv
// Checker for the receive descriptor ring writer: per-cycle rules on the
// memory handshake, register locking, sticky flag and buffer bounds.
module rxq_ring_chk #(
    parameter int BUF_BYTES = 128,
    parameter int IDX_W     = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             loop_en,
    input logic [31:0]      q_base,
    input logic             bna,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             rx_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [31:0]      mem_addr,
    input logic [IDX_W-1:0] idx,
    input logic             state_wdata,
    input logic [31:0]      buf_base
);
    // R11: an unacknowledged request keeps address and direction
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8 and R9: configuration is frozen while reception is enabled
    p_cfg_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> $stable(q_base));
    p_loop_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> $stable(loop_en));

    // R7: flag stays set unless a clearing control write occurs
    p_bna_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bna && !(reg_wr && !reg_addr && reg_wdata[2]) |=> bna);

    // R10: disabling returns the ring position to the base
    p_idx_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> idx == '0);

    // R11: ports are quiet once reception is off
    p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_ready && !mem_req);

    // R3: data writes stay within the current buffer
    p_in_buffer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_wdata && mem_req |-> (mem_addr - buf_base) < 32'(BUF_BYTES));
endmodule

bind rxq_ring_dma rxq_ring_chk #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .loop_en(lb_mode),
    .q_base(q_base), .bna(bna), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_ready(rx_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .idx(idx),
    .state_wdata(state_wdata), .buf_base(buf_base)
);

// File: tb/tb_rxq_ring_dma.sv
module tb_rxq_ring_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        lb_mode;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [31:0] mem [0:4095];
    int checks = 0, errors = 0;
    int e = 0;

    localparam int NFR = 8;
    localparam int FR_LEN  [NFR] = '{1, 4, 5, 127, 128, 129, 300, 64};
    localparam int FR_BUFS [NFR] = '{1, 1, 1, 1, 1, 2, 3, 1};
    localparam int FR_SEED [NFR] = '{8'h10, 8'h20, 8'h33, 8'h40, 8'h51, 8'h60, 8'h7a, 8'h80};

    always #2.5 clk = ~clk;

    rxq_ring_dma dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lb_mode(lb_mode),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_ready(rx_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model: acknowledge one cycle after each request
    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && !mem_ack) begin
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[13:2]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            logic r;
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(seed + i);
            rx_sof = (i == 0); rx_eof = (i == len - 1);
            forever begin
                r = rx_ready;
                @(posedge clk);
                if (r) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    function automatic logic [31:0] buf_of(input int k);
        return 32'h2000 + 32'(128 * k);
    endfunction

    // checks one closed descriptor and the bytes of its buffer
    task automatic check_desc(input int d, input int count, input bit sof, input bit eof,
                              input int first_byte);
        logic [31:0] w0, w1, got;
        int bad;
        w0 = mem[2*d];
        w1 = mem[2*d + 1];
        check("R4 word0 writeback", w0, buf_of(d) | ((d == 7) ? 32'h2 : 32'h0) | 32'h1);
        check("R4 word1 count/flags", w1, 32'(count) | (sof ? 32'h4000 : 0) | (eof ? 32'h8000 : 0));
        bad = 0;
        for (int j = 0; j < count; j++) begin
            got = mem[(buf_of(d) + 32'(j)) >> 2] >> (8 * (j % 4));
            if (got[7:0] !== 8'(first_byte + j)) bad++;
        end
        check("R2 packed buffer bytes", 32'(bad), 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rd, saved;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int k = 0; k < 8; k++) mem[2*k] = buf_of(k) | ((k == 7) ? 32'h2 : 32'h0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state, R11 quiet ports
        reg_read(1'b0, rd); check("R10 control after reset", rd, 32'h0);
        reg_read(1'b1, rd); check("R10 qptr after reset", rd, 32'h0);
        check("R11 rx_ready off", {31'd0, rx_ready}, 32'h0);
        check("R11 mem_req off", {31'd0, mem_req}, 32'h0);

        reg_write(1'b1, 32'h0);
        reg_write(1'b0, 32'h1);

        // table walk: R1 R2 R3 R4 R5
        for (int f = 0; f < NFR; f++) begin
            send_frame(FR_LEN[f], FR_SEED[f]);
            for (int b = 0; b < FR_BUFS[f]; b++) begin
                int rem;
                rem = FR_LEN[f] - 128 * b;
                check_desc(e, (rem > 128) ? 128 : rem, b == 0, b == FR_BUFS[f] - 1,
                           FR_SEED[f] + 128 * b);
                mem[2*e] = mem[2*e] & ~32'h1;
                e = (e == 7) ? 0 : e + 1;   // R5 wrap at entry 7
            end
            reg_read(1'b1, rd); check("R1 R5 qptr after frame", rd, 32'(8 * e));
        end

        // R7: refused first descriptor, drop, sticky flag, retry
        mem[2*e] = mem[2*e] | 32'h1;
        saved = mem[2*e + 1];
        send_frame(20, 8'h90);
        reg_read(1'b0, rd); check("R7 flag set", rd, 32'h5);
        reg_read(1'b1, rd); check("R7 entry kept", rd, 32'(8 * e));
        check("R7 nothing written", mem[2*e + 1], saved);
        reg_write(1'b0, 32'h5);
        reg_read(1'b0, rd); check("R7 flag cleared", rd, 32'h1);
        mem[2*e] = mem[2*e] & ~32'h1;
        send_frame(5, 8'ha0);
        check_desc(e, 5, 1, 1, 8'ha0);
        mem[2*e] = mem[2*e] & ~32'h1;
        e = (e == 7) ? 0 : e + 1;

        // R7 and R3: second buffer refused mid-frame
        mem[2*((e + 1) % 8)] = mem[2*((e + 1) % 8)] | 32'h1;
        send_frame(200, 8'hb0);
        check_desc(e, 128, 1, 0, 8'hb0);
        reg_read(1'b0, rd); check("R7 flag mid-frame", rd, 32'h5);
        reg_read(1'b1, rd); check("R7 retry entry", rd, 32'(8 * ((e + 1) % 8)));
        mem[2*e] = mem[2*e] & ~32'h1;
        mem[2*((e + 1) % 8)] = mem[2*((e + 1) % 8)] & ~32'h1;
        e = (e + 1) % 8;
        reg_write(1'b0, 32'h5);

        // R8 and R9: locked while enabled
        reg_write(1'b1, 32'h400);
        reg_read(1'b1, rd); check("R8 qptr locked", rd, 32'(8 * e));
        reg_write(1'b0, 32'h3);
        reg_read(1'b0, rd); check("R9 loopback locked", rd, 32'h1);
        reg_write(1'b0, 32'h2);
        reg_read(1'b0, rd); check("R9 change with disable ignored", rd, 32'h0);
        reg_read(1'b1, rd); check("R10 disable returns to base", rd, 32'h0);
        reg_write(1'b0, 32'h2);
        reg_read(1'b0, rd); check("R9 loopback set while off", rd, 32'h2);
        check("R9 lb_mode pin", {31'd0, lb_mode}, 32'h1);

        // R6: 1024 entries with no wrap marker
        for (int k = 0; k < 1024; k++) begin
            mem[2*k] = 32'h2000;
            mem[2*k + 1] = '0;
        end
        reg_write(1'b1, 32'h0);
        reg_write(1'b0, 32'h3);
        for (int k = 0; k < 1023; k++) send_frame(1, k);
        reg_read(1'b1, rd); check("R6 last entry", rd, 32'(8 * 1023));
        send_frame(1, 8'hee);
        check("R6 entry 1023 used", mem[2*1023 + 1], 32'h0000_c001);
        reg_read(1'b1, rd); check("R6 wrap to base", rd, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule